// File: doc/BRIEF.md
# Saturating Receive Statistics and Interrupt Status

This block keeps the receive-side statistics of one MAC direction and turns notable events into a single level interrupt. A frame parser upstream presents one pulse per finished frame, together with its length and a set of classification flags (dropped, CRC error, pause, multicast, broadcast). From these, eight counters are kept: received frames, received bytes, dropped frames, dropped bytes, CRC errors, pause frames, multicast frames and broadcast frames. None of them wraps: each holds at all ones once full.

A nine-bit status word records a successfully received frame and the overflow of each counter. Software reads and writes the counters, the status word, a mask word and a force (mirror) word through a small register port with a combinational read path. Status bits are cleared by writing ones to them. Writing ones to the mirror address sets them, which lets software test its interrupt handler. The interrupt output is high while any unmasked status bit is set. A direction enable input freezes the counters and blocks new hardware-raised status bits, while leaving existing bits in place.

Top module: `rx_stats_irq`

## Requirements
- R1: Every counter is CNT_W bits wide (default 32) and saturates: once it would pass all ones it holds all ones and never wraps.
- R2: While dir_en is 0 no counter changes, whatever the frame inputs do.
- R3: The received byte counter adds frm_len for every frame, dropped or not. The dropped byte counter adds frm_len only for frames with frm_drop set.
- R4: The frame counter increments on every frame. The dropped, CRC error, pause, multicast and broadcast counters each increment on a frame whose matching flag is 1.
- R5: Status bit 0 sets on a frame with frm_drop at 0. Status bit k+1 sets when an update would carry counter k past its maximum, with counters numbered 0 rx frames, 1 rx bytes, 2 dropped frames, 3 dropped bytes, 4 CRC errors, 5 pause, 6 multicast, 7 broadcast.
- R6: A write to address 0 clears each status bit whose data bit is 1. Reads of address 0 and address 2 both return the status word in bits 8:0.
- R7: A write to address 2 sets each status bit whose data bit is 1, whether the direction is enabled or not.
- R8: Hardware events set status bits only while dir_en is 1. Bits already set stay set when dir_en falls.
- R9: The mask lives at address 1 (bits 8:0, reset 0). irq is 1 exactly when some status bit is 1 and its mask bit is 0.
- R10: When a hardware event and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R11: Counter k reads at address 8+k, zero extended; every other address reads 0. After reset all counters, status, mask and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_en | input | 1 | Direction enable; 0 freezes counters and hardware status setting |
| frm_valid | input | 1 | One-cycle pulse per finished frame |
| frm_len | input | LEN_W | Frame length in bytes, all bytes included |
| frm_drop | input | 1 | Frame was dropped |
| frm_crc_err | input | 1 | Frame had a CRC error |
| frm_pause | input | 1 | Frame was a pause frame |
| frm_mcast | input | 1 | Frame was multicast |
| frm_bcast | input | 1 | Frame was broadcast |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
A frame pulse or register write is registered at the next rising edge, so counters, status and irq show its effect one cycle later, and read data follows reg_addr within the same cycle. The bench drives every input on the falling edge, lets one rising edge pass, and reads back on the next falling edge, so each check sees exactly one update. The same-cycle set and clear case is driven in a single falling-edge slot so that both land on one rising edge.

// File: rtl/rx_stats_pkg.sv
package rx_stats_pkg;

  localparam int NUM_CNT = 8;
  localparam int NUM_STS = NUM_CNT + 1;

  typedef enum logic [2:0] {
    CID_RX_FRM   = 3'd0,
    CID_RX_BYTE  = 3'd1,
    CID_DRP_FRM  = 3'd2,
    CID_DRP_BYTE = 3'd3,
    CID_CRC      = 3'd4,
    CID_PAUSE    = 3'd5,
    CID_MCAST    = 3'd6,
    CID_BCAST    = 3'd7
  } cnt_id_e;

  localparam logic [3:0] ADR_STATUS = 4'd0;
  localparam logic [3:0] ADR_MASK   = 4'd1;
  localparam logic [3:0] ADR_FORCE  = 4'd2;

endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inc_vld,
  input  logic [CNT_W-1:0] inc_amt,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W:0] wide_add(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [CNT_W:0] sum;
  logic           upd;

  assign sum     = wide_add(count, inc_amt);
  assign upd     = en && inc_vld;
  assign ovf_evt = upd && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (upd)     count <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  // R1
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  // R5
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count == CNT_MAX));

endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NSTS = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NSTS-1:0] hw_evt,
  input  logic            clr_we,
  input  logic            frc_we,
  input  logic            msk_we,
  input  logic [NSTS-1:0] wdata,
  output logic [NSTS-1:0] sts,
  output logic [NSTS-1:0] mask,
  output logic            irq
);

  logic [NSTS-1:0] set_bits;
  logic [NSTS-1:0] clr_bits;

  assign set_bits = (en ? hw_evt : '0) | (frc_we ? wdata : '0);
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= '0;
      mask <= '0;
    end else begin
      sts <= (sts & ~clr_bits) | set_bits;
      if (msk_we) mask <= wdata;
    end
  end

  assign irq = |(sts & ~mask);

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !frc_we && !en) |=> ((sts & $past(wdata)) == '0));

  // R7
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc_we |=> ((sts & $past(wdata)) == $past(wdata)));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_we && !frc_we) |=> $stable(sts));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (|hw_evt)) |=> ((sts & $past(hw_evt)) == $past(hw_evt)));

endmodule

// File: rtl/rx_stats_irq.sv
module rx_stats_irq
  import rx_stats_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 14,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_en,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             frm_drop,
  input  logic             frm_crc_err,
  input  logic             frm_pause,
  input  logic             frm_mcast,
  input  logic             frm_bcast,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_CNT-1:0]  inc_vld;
  logic [CNT_W-1:0]    inc_amt [NUM_CNT];
  logic [CNT_W-1:0]    cnt     [NUM_CNT];
  logic [NUM_CNT-1:0]  ovf_evt;
  logic [CNT_W-1:0]    len_ext;
  logic [NUM_STS-1:0]  hw_evt;
  logic [NUM_STS-1:0]  sts;
  logic [NUM_STS-1:0]  mask;
  logic                frame_ok;
  logic                clr_we;
  logic                frc_we;
  logic                msk_we;
  logic                unused_wdata;

  assign len_ext      = CNT_W'(frm_len);
  assign unused_wdata = ^reg_wdata[REG_W-1:NUM_STS];

  // Per-counter increment selection, indexed by the counter id.
  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      inc_vld[k] = 1'b0;
      inc_amt[k] = ONE;
      case (cnt_id_e'(k))
        CID_RX_FRM:   inc_vld[k] = frm_valid;
        CID_RX_BYTE:  begin inc_vld[k] = frm_valid; inc_amt[k] = len_ext; end
        CID_DRP_FRM:  inc_vld[k] = frm_valid && frm_drop;
        CID_DRP_BYTE: begin inc_vld[k] = frm_valid && frm_drop; inc_amt[k] = len_ext; end
        CID_CRC:      inc_vld[k] = frm_valid && frm_crc_err;
        CID_PAUSE:    inc_vld[k] = frm_valid && frm_pause;
        CID_MCAST:    inc_vld[k] = frm_valid && frm_mcast;
        CID_BCAST:    inc_vld[k] = frm_valid && frm_bcast;
        default:      inc_vld[k] = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (dir_en),
      .inc_vld (inc_vld[g]),
      .inc_amt (inc_amt[g]),
      .count   (cnt[g]),
      .ovf_evt (ovf_evt[g])
    );
  end

  assign frame_ok = frm_valid && !frm_drop;
  assign hw_evt   = {ovf_evt, frame_ok};

  assign clr_we = reg_wr && (reg_addr == ADR_STATUS);
  assign msk_we = reg_wr && (reg_addr == ADR_MASK);
  assign frc_we = reg_wr && (reg_addr == ADR_FORCE);

  irq_status #(.NSTS(NUM_STS)) u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (dir_en),
    .hw_evt (hw_evt),
    .clr_we (clr_we),
    .frc_we (frc_we),
    .msk_we (msk_we),
    .wdata  (reg_wdata[NUM_STS-1:0]),
    .sts    (sts),
    .mask   (mask),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[3])                  reg_rdata = REG_W'(cnt[reg_addr[2:0]]);
    else if (reg_addr == ADR_STATUS)  reg_rdata = REG_W'(sts);
    else if (reg_addr == ADR_FORCE)   reg_rdata = REG_W'(sts);
    else if (reg_addr == ADR_MASK)    reg_rdata = REG_W'(mask);
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask == '1) && !reg_wr) |=> !irq);

endmodule

// File: tb/rx_stats_irq_tb.sv
module rx_stats_irq_tb;

  localparam int CNT_W = 12;
  localparam int LEN_W = 8;
  localparam int REG_W = 32;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dir_en = 1'b0;
  logic             frm_valid = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic             frm_drop = 1'b0, frm_crc_err = 1'b0, frm_pause = 1'b0;
  logic             frm_mcast = 1'b0, frm_bcast = 1'b0;
  logic [3:0]       reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             irq;

  always #2.5 clk = ~clk;

  rx_stats_irq #(.CNT_W(CNT_W), .LEN_W(LEN_W), .REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_en(dir_en), .frm_valid(frm_valid),
    .frm_len(frm_len), .frm_drop(frm_drop), .frm_crc_err(frm_crc_err),
    .frm_pause(frm_pause), .frm_mcast(frm_mcast), .frm_bcast(frm_bcast),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  int m_cnt [8];
  logic [8:0] m_sts  = '0;
  logic [8:0] m_mask = '0;
  logic       m_en   = 1'b0;

  // {ok, drop, crc, pause, mcast, bcast, len}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 5'b00000, 8'd64},
    {1'b1, 5'b00010, 8'd100},
    {1'b0, 5'b11000, 8'd200},
    {1'b0, 5'b10100, 8'd72},
    {1'b1, 5'b00001, 8'd128},
    {1'b1, 5'b00000, 8'd0},
    {1'b0, 5'b10010, 8'd255},
    {1'b1, 5'b01000, 8'd90}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'd0) m_sts = m_sts & ~d[8:0];
    if (a == 4'd1) m_mask = d[8:0];
    if (a == 4'd2) m_sts = m_sts | d[8:0];
  endtask

  task automatic bump(input int k, input int amt);
    if (m_cnt[k] + amt > MAXV) begin
      m_cnt[k] = MAXV;
      m_sts[k+1] = 1'b1;
    end else begin
      m_cnt[k] = m_cnt[k] + amt;
    end
  endtask

  task automatic model_frame(input int len, input logic [4:0] fl);
    if (m_en) begin
      bump(0, 1);
      bump(1, len);
      if (fl[4]) begin bump(2, 1); bump(3, len); end
      if (fl[3]) bump(4, 1);
      if (fl[2]) bump(5, 1);
      if (fl[1]) bump(6, 1);
      if (fl[0]) bump(7, 1);
      if (!fl[4]) m_sts[0] = 1'b1;
    end
  endtask

  // Drives n back-to-back frames with the same length and flags.
  task automatic send(input int len, input logic [4:0] fl, input int n);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = LEN_W'(len);
    {frm_drop, frm_crc_err, frm_pause, frm_mcast, frm_bcast} = fl;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_frame(len, fl);
    end
    frm_valid = 1'b0;
    {frm_drop, frm_crc_err, frm_pause, frm_mcast, frm_bcast} = '0;
  endtask

  task automatic set_en(input logic e);
    @(negedge clk);
    dir_en = e; m_en = e;
  endtask

  task automatic chk_all(input string req);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(4'(8 + k), d);
      chk(req, d, 32'(m_cnt[k]));
    end
    rd(4'd0, d);
    chk({req, " R5 status"}, d, 32'(m_sts));
    rd(4'd2, d);
    chk("R6 mirror read", d, 32'(m_sts));
    chk("R9 irq", 32'(irq), 32'(|(m_sts & ~m_mask)));
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    for (int k = 0; k < 8; k++) m_cnt[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state and unmapped addresses
    chk_all("R11 reset");
    rd(4'd1, d);  chk("R11 mask reset", d, 0);
    rd(4'd5, d);  chk("R11 unmapped read", d, 0);

    set_en(1'b1);

    // R3 R4 R5 vector walk
    foreach (VEC[i]) begin
      wr(4'd0, 32'h1FF);
      send(int'(VEC[i][7:0]), VEC[i][12:8], 1);
      rd(4'd0, d);
      chk("R5 frame ok bit", 32'(d[0]), 32'(VEC[i][13]));
      chk_all("R3 R4 counters");
    end

    // R9 masking
    wr(4'd2, 32'h001);
    wr(4'd1, 32'h001);
    chk("R9 masked irq", 32'(irq), 0);
    wr(4'd1, 32'h000);
    chk("R9 unmasked irq", 32'(irq), 1);

    // R6 write one to clear
    wr(4'd0, 32'h1FF);
    chk_all("R6 clear");

    // R2 R8 disabled direction freezes counters, no new status
    set_en(1'b0);
    send(50, 5'b11111, 3);
    chk_all("R2 R8 stall");

    // R7 force while disabled, R8 bits stay
    wr(4'd2, 32'h1A5);
    chk_all("R7 force");
    repeat (4) @(negedge clk);
    chk_all("R8 sticky");
    wr(4'd0, 32'h1FF);
    set_en(1'b1);

    // R10 hardware set beats clear in the same cycle
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 8'd10;
    reg_addr = 4'd0; reg_wdata = 32'h001; reg_wr = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0; reg_wr = 1'b0;
    m_sts[0] = 1'b1;
    model_frame(10, 5'b00000);
    chk_all("R10 set wins");

    // R1 R5 byte counter saturation and overflow bit 2
    wr(4'd0, 32'h1FF);
    send(255, 5'b10000, 20);
    chk_all("R1 byte saturate");
    rd(4'd0, d);
    chk("R5 byte ovf bit2", 32'(d[2]), 1);
    chk("R5 drop byte ovf bit4", 32'(d[4]), 1);

    // R1 R5 frame counter saturation, re-raise after clear
    send(0, 5'b00000, 4100);
    chk_all("R1 frame saturate");
    wr(4'd0, 32'h1FF);
    send(0, 5'b00000, 1);
    rd(4'd0, d);
    chk("R5 frame ovf re-raise", 32'(d[1]), 1);
    chk_all("R1 hold");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule